// File: doc/BRIEF.md
# Byte-Sliced AES Round Linear Layer

This block carries out the linear half of one AES round on eight independent AES states at the same time. The eight states are held byte-sliced. Each 64-bit word collects the byte at one fixed position from all eight 16-byte blocks, one byte per lane. One word holds that byte for every block, so row rotation only reorders words. Every field addition becomes a single 64-bit XOR. Each column-mixing coefficient acts on a whole word at once. The block expects bytes that byte substitution has already processed. It does not expand keys and it does not sequence rounds.

A caller presents sixteen state words, one 128-bit round key shared by all eight instances, a last-round flag and a valid strobe. One clock later the block returns the rotated, mixed and key-added words with a valid strobe. When the last-round flag is set, column mixing is left out. A two-state output controller tracks whether the output register holds a fresh result. Its states are `ST_EMPTY` and `ST_FULL`. It moves from `ST_EMPTY` to `ST_FULL` on an accepted input (`GO_LOAD`), stays in `ST_FULL` on back-to-back inputs (`GO_RELOAD`), and returns to `ST_EMPTY` on a cycle with no input (`GO_DRAIN`). Reset forces `ST_EMPTY`.

Top module: `aesbs_linear_round`

## Requirements
- R1: Word j (0..15) sits at `state_in[64*j+63 : 64*j]`, and lane i (0..7) of every word sits at bits `[8*i+7 : 8*i]` of that word and belongs to instance i. Byte j of an instance is at row j mod 4 and column j div 4. Byte 0 of a 128-bit block is its most significant byte. `state_out` uses the same layout.
- R2: Row rotation: output row r, column c takes input row r, column (c+r) mod 4. This is a pure word selection.
- R3: Column mixing: for each column with rows a0..a3, output row r equals 2·a[r] ⊕ 3·a[r+1] ⊕ a[r+2] ⊕ a[r+3], with indices taken mod 4. The product 3·x is computed as 2·x ⊕ x.
- R4: Doubling in each lane shifts that lane left by one bit and does not carry into the next lane. If the lane's top bit was 1, the lane is then XORed with 0x1B.
- R5: Key addition: key byte j is `round_key[127-8*j -: 8]`. It is copied into all eight lanes and XORed into output word j.
- R6: When `final_round` is 1, column mixing is skipped and the result is row rotation followed by key addition.
- R7: Every lane of the output equals one scalar AES linear round applied to that lane's block alone.
- R8: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. `state_out` changes only in the cycle after an accepted input and otherwise holds its value.
- R9: A synchronous active-high `rst` clears `out_valid` and `state_out` to 0 on the next clock edge, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input words and key are accepted this cycle |
| final_round | input | 1 | Skip column mixing for this input |
| state_in | input | 1024 | Sixteen byte-sliced state words |
| round_key | input | 128 | Round key shared by all eight instances |
| out_valid | output | 1 | `state_out` holds a result accepted one cycle earlier |
| state_out | output | 1024 | Sixteen updated byte-sliced state words |

## Verification
A wrong word selection or a wrong mixing coefficient shows up at the ports in the cycle right after the input is accepted. It corrupts whole words, so the same bytes are wrong in all eight lanes. A doubling that lets a carry cross a lane boundary corrupts only the lane next to a byte with its top bit set. Saturated bytes such as 0x80 and 0xFF expose this at once. A controller stuck in the wrong state shows as a valid strobe that is missing, or that lingers for one cycle beyond a single input.

// File: rtl/aesbs_pkg.sv
package aesbs_pkg;

    localparam int ROWS      = 4;
    localparam int COLS      = 4;
    localparam int WORDS     = ROWS * COLS;
    localparam int KEY_W     = 8 * WORDS;
    localparam logic [7:0] REDUCE_POLY = 8'h1B;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    // Source word index for output word j under the row rotation.
    function automatic int rot_src(input int j);
        int r;
        int c;
        r = j % ROWS;
        c = j / ROWS;
        return r + ROWS * ((c + r) % COLS);
    endfunction

endpackage

// File: rtl/aesbs_shift_rows.sv
module aesbs_shift_rows
    import aesbs_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int BUS_W = WORDS * WORD_W
) (
    input  logic [BUS_W-1:0] words_in,
    output logic [BUS_W-1:0] words_out
);

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        localparam int SRC = rot_src(j);
        assign words_out[j*WORD_W +: WORD_W] = words_in[SRC*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/aesbs_xtime.sv
module aesbs_xtime
    import aesbs_pkg::*;
#(
    parameter int LANES = 8,
    localparam int WORD_W = 8 * LANES
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane;
        logic [7:0] shifted;
        assign lane     = word_in[8*i +: 8];
        assign shifted  = {lane[6:0], 1'b0};
        assign word_out[8*i +: 8] = lane[7] ? (shifted ^ REDUCE_POLY) : shifted;
    end

endmodule

// File: rtl/aesbs_mix_column.sv
module aesbs_mix_column
    import aesbs_pkg::*;
#(
    parameter int LANES = 8,
    localparam int WORD_W = 8 * LANES,
    localparam int COL_W  = ROWS * WORD_W
) (
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);

    logic [WORD_W-1:0] a  [ROWS];
    logic [WORD_W-1:0] a2 [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign a[r] = col_in[r*WORD_W +: WORD_W];

        aesbs_xtime #(.LANES(LANES)) u_dbl (
            .word_in  (a[r]),
            .word_out (a2[r])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_out
        localparam int R1 = (r + 1) % ROWS;
        localparam int R2 = (r + 2) % ROWS;
        localparam int R3 = (r + 3) % ROWS;
        // 2*a[r] ^ 3*a[r+1] ^ a[r+2] ^ a[r+3]
        assign col_out[r*WORD_W +: WORD_W] =
            a2[r] ^ a2[R1] ^ a[R1] ^ a[R2] ^ a[R3];
    end

endmodule

// File: rtl/aesbs_linear_round.sv
module aesbs_linear_round
    import aesbs_pkg::*;
#(
    parameter int LANES = 8,
    localparam int WORD_W = 8 * LANES,
    localparam int BUS_W  = WORDS * WORD_W,
    localparam int COL_W  = ROWS * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             final_round,
    input  logic [BUS_W-1:0] state_in,
    input  logic [KEY_W-1:0] round_key,
    output logic             out_valid,
    output logic [BUS_W-1:0] state_out
);

    logic [BUS_W-1:0] rotated;
    logic [BUS_W-1:0] mixed;
    logic [BUS_W-1:0] pre_key;
    logic [BUS_W-1:0] keyed;
    logic [BUS_W-1:0] data_q;
    out_state_e       fsm_q;
    out_state_e       fsm_d;

    aesbs_shift_rows #(.WORD_W(WORD_W)) u_rot (
        .words_in  (state_in),
        .words_out (rotated)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        aesbs_mix_column #(.LANES(LANES)) u_mix (
            .col_in  (rotated[c*COL_W +: COL_W]),
            .col_out (mixed[c*COL_W +: COL_W])
        );
    end

    assign pre_key = final_round ? rotated : mixed;

    for (genvar j = 0; j < WORDS; j++) begin : g_key
        assign keyed[j*WORD_W +: WORD_W] =
            pre_key[j*WORD_W +: WORD_W] ^ {LANES{round_key[KEY_W-1-8*j -: 8]}};
    end

    // Next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_EMPTY: if (in_valid)  fsm_d = ST_FULL;   // GO_LOAD
            ST_FULL:  if (!in_valid) fsm_d = ST_EMPTY;  // GO_DRAIN, else GO_RELOAD
            default:                 fsm_d = ST_EMPTY;
        endcase
    end

    // State and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= ST_EMPTY;
            data_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (in_valid) data_q <= keyed;
        end
    end

    // Outputs
    always_comb begin
        out_valid = (fsm_q == ST_FULL);
        state_out = data_q;
    end

endmodule

// File: rtl/aesbs_linear_round_chk.sv
module aesbs_linear_round_chk
    import aesbs_pkg::*;
#(
    parameter int LANES = 8,
    localparam int WORD_W = 8 * LANES,
    localparam int BUS_W  = WORDS * WORD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             final_round,
    input logic [BUS_W-1:0] state_in,
    input logic [KEY_W-1:0] round_key,
    input logic             out_valid,
    input logic [BUS_W-1:0] state_out
);

    logic [BUS_W-1:0] key_fill;
    for (genvar j = 0; j < WORDS; j++) begin : g_fill
        assign key_fill[j*WORD_W +: WORD_W] = {LANES{round_key[KEY_W-1-8*j -: 8]}};
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state_out)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && state_out == '0)); // R9
    AST_KEY_BROADCAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state_in == '0) |=> state_out == $past(key_fill)); // R5
    AST_ROW1_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && final_round && round_key == '0)
        |=> state_out[WORD_W +: WORD_W] == $past(state_in[5*WORD_W +: WORD_W])); // R2 R6
    AST_ROW0_FIXED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && final_round && round_key == '0)
        |=> state_out[WORD_W-1:0] == $past(state_in[WORD_W-1:0])); // R2 R6

endmodule

bind aesbs_linear_round aesbs_linear_round_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .final_round (final_round),
    .state_in    (state_in),
    .round_key   (round_key),
    .out_valid   (out_valid),
    .state_out   (state_out)
);

// File: tb/aesbs_linear_round_test.sv
module aesbs_linear_round_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int NVEC  = 10;

    localparam logic [127:0] VKEY [NVEC] = '{
        128'h000102030405060708090a0b0c0d0e0f,
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'hffffffffffffffffffffffffffffffff,
        128'h00000000000000000000000000000000,
        128'h80808080808080808080808080808080,
        128'hd6aa74fdd2af72fadaa678f1d6ab76fe,
        128'h1b1b1b1b00000000ffffffff5a5a5a5a,
        128'h0123456789abcdeffedcba9876543210,
        128'hc0ffee00deadbeef0badf00d12345678,
        128'h5555aaaa5555aaaa3333cccc3333cccc
    };
    localparam logic VFIN [NVEC] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          final_round = 1'b0;
    logic [1023:0] state_in = '0;
    logic [127:0]  round_key = '0;
    logic          out_valid;
    logic [1023:0] state_out;

    int checks = 0;
    int fails  = 0;
    logic [127:0] blk [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    aesbs_linear_round #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .final_round(final_round),
        .state_in(state_in), .round_key(round_key),
        .out_valid(out_valid), .state_out(state_out)
    );

    function automatic logic [7:0] gdbl(input logic [7:0] b);
        return b[7] ? ({b[6:0], 1'b0} ^ 8'h1B) : {b[6:0], 1'b0};
    endfunction

    // Scalar reference round on one block (byte 0 = MSB).
    function automatic logic [127:0] ref_round(input logic [127:0] blkin,
                                               input logic [127:0] key, input logic fin);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] m [16];
        logic [127:0] res;
        for (int j = 0; j < 16; j++) s[j] = blkin[127-8*j -: 8];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                t[r+4*c] = s[r + 4*((c+r)%4)];
        for (int c = 0; c < 4; c++) begin
            m[4*c+0] = gdbl(t[4*c]) ^ gdbl(t[4*c+1]) ^ t[4*c+1] ^ t[4*c+2] ^ t[4*c+3];
            m[4*c+1] = t[4*c] ^ gdbl(t[4*c+1]) ^ gdbl(t[4*c+2]) ^ t[4*c+2] ^ t[4*c+3];
            m[4*c+2] = t[4*c] ^ t[4*c+1] ^ gdbl(t[4*c+2]) ^ gdbl(t[4*c+3]) ^ t[4*c+3];
            m[4*c+3] = gdbl(t[4*c]) ^ t[4*c] ^ t[4*c+1] ^ t[4*c+2] ^ gdbl(t[4*c+3]);
        end
        for (int j = 0; j < 16; j++)
            res[127-8*j -: 8] = (fin ? t[j] : m[j]) ^ key[127-8*j -: 8];
        return res;
    endfunction

    function automatic logic [127:0] rand128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic pack_blocks();
        for (int j = 0; j < 16; j++)
            for (int i = 0; i < LANES; i++)
                state_in[64*j + 8*i +: 8] = blk[i][127-8*j -: 8];
    endtask

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply blk[] with key/fin for one cycle, then compare all lanes.
    task automatic run_case(input string tag, input logic [127:0] key, input logic fin);
        logic [127:0] got;
        @(negedge clk);
        pack_blocks();
        round_key = key;
        final_round = fin;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < 16; j++) got[127-8*j -: 8] = state_out[64*j + 8*i +: 8];
            check($sformatf("%s R7 R1 lane %0d", tag, i), got, ref_round(blk[i], key, fin));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [1023:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset data", state_out[127:0], 128'd0);

        // Table walk: random states, per-vector key and mode.
        for (int v = 0; v < NVEC; v++) begin
            for (int i = 0; i < LANES; i++) blk[i] = rand128();
            run_case(VFIN[v] ? "R6 table" : "R3 table", VKEY[v], VFIN[v]);
        end

        // R4: saturated bytes force reduction in every lane, adjacent lanes differ.
        for (int i = 0; i < LANES; i++) blk[i] = (i % 2) ? {16{8'h80}} : {16{8'hFF}};
        run_case("R4 saturated", 128'd0, 1'b0);
        for (int i = 0; i < LANES; i++) blk[i] = (i % 2) ? {16{8'h7F}} : {16{8'h80}};
        run_case("R4 alternating", 128'h0f0e0d0c0b0a09080706050403020100, 1'b0);

        // R5: zero state, output is the broadcast key.
        for (int i = 0; i < LANES; i++) blk[i] = '0;
        run_case("R5 zero state", 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);

        // R2: byte j holds j, last round, zero key -> pure rotation.
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < 16; j++) blk[i][127-8*j -: 8] = 8'(j + 16*i);
        run_case("R2 rotation", 128'd0, 1'b1);

        // R8: idle cycle with new inputs, output holds and valid drops.
        held = state_out;
        @(negedge clk);
        state_in = {8{rand128()}};
        round_key = rand128();
        @(negedge clk);
        check("R8 idle valid", {127'd0, out_valid}, 128'd0);
        check("R8 hold data", state_out[127:0], held[127:0]);
        check("R8 hold data hi", state_out[1023:896], held[1023:896]);

        // R8: back-to-back inputs keep valid high.
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 back-to-back valid", {127'd0, out_valid}, 128'd1);
        in_valid = 1'b0;

        // R9: reset while input is valid.
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 reset over input valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset over input data", state_out[127:0], 128'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule